// File: doc/BRIEF.md
# Counter-Based Control Word Generator

This block converts the up and down enables coming from a phase detector into a control value for a digitally controlled oscillator. It holds two 6-bit counters that move in opposite directions. The rising counter starts at zero and counts toward all ones when told to speed up. The falling counter starts at all ones and counts toward zero when told to slow down. An adder built as a carry chain sums the two counter values into a 7-bit binary word. After reset the word sits at mid-scale, 63.

A binary-to-thermometer decoder expands the word into a 128-position code. Position i is set when i is below the word. The sum can never exceed 126, so the top two positions are always clear. They are dropped, and the block exposes 126 thermometer lines. Both outputs are registered. An enable sampled at one rising edge shows up on both outputs right after that same edge.

The enables are plain level controls with no handshake. They are sampled on every clock and carry no back-pressure.

Top module: `ctrl_word_gen`

## Requirements
- R1: While reset is held low, and on the first cycle after it is released with no enable, the word reads 63 and thermometer lines 0 to 62 are 1 while lines 63 to 125 are 0.
- R2: With only the up enable high, the word rises by exactly 1 per cycle while the rising counter is below 63.
- R3: With only the down enable high, the word falls by exactly 1 per cycle while the falling counter is above 0.
- R4: With both enables high, each counter takes its own step, so the word is unchanged unless one counter is already at its limit.
- R5: The rising counter stops at 63 and never wraps to 0. Further up enables leave the word unchanged.
- R6: The falling counter stops at 0 and never wraps to 63. Further down enables leave the word unchanged.
- R7: With neither enable high, the word and the thermometer lines hold their values.
- R8: Thermometer line i (bit i of the output, i from 0 to 125) is 1 exactly when i is less than the word. The two positions above 125 are never set.
- R9: An enable sampled at a rising clock edge is reflected in both outputs immediately after that same edge, a latency of one cycle.
- R10: The word always equals the rising counter plus the falling counter, and it stays within 0 to 126.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| up_en | input | 1 | Step the rising counter up on this cycle |
| dn_en | input | 1 | Step the falling counter down on this cycle |
| ctrl_word | output | 7 | Registered binary control value, from 0 to 126 |
| therm_code | output | 126 | Registered thermometer code; bit i is 1 when i is below ctrl_word |

## Verification
A counter left in a wrong state shows up on the word at the next edge. It appears as an off-by-one step, a missed hold, or a wrap past its limit. A scoreboard that models both counters catches that mismatch within one cycle of the enable that caused it. A decoder fault shows up as a thermometer line that disagrees with its index. The full 126-line vector is therefore compared on every cycle, not just its bit count. Long runs against each limit, and runs with both enables high, expose saturation faults. Those faults would otherwise surface only after 63 or more steps.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
  typedef enum logic {
    CNT_RISE = 1'b0,
    CNT_FALL = 1'b1
  } cnt_dir_e;
endpackage

// File: rtl/cwg_sat_counter.sv
module cwg_sat_counter #(
  parameter int W = 6,
  parameter cwg_pkg::cnt_dir_e DIR = cwg_pkg::CNT_RISE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic [W-1:0] cnt_d_o,
  output logic [W-1:0] cnt_q_o
);
  localparam logic [W-1:0] ALL_ONE = '1;
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] RST_VAL = (DIR == cwg_pkg::CNT_RISE) ? '0 : ALL_ONE;
  localparam logic [W-1:0] LIMIT   = (DIR == cwg_pkg::CNT_RISE) ? ALL_ONE : '0;

  logic at_limit;
  assign at_limit = (cnt_q_o == LIMIT);

  generate
    if (DIR == cwg_pkg::CNT_RISE) begin : g_rise
      always_comb begin
        cnt_d_o = cnt_q_o;
        if (step_i && !at_limit) cnt_d_o = cnt_q_o + ONE;
      end
    end else begin : g_fall
      always_comb begin
        cnt_d_o = cnt_q_o;
        if (step_i && !at_limit) cnt_d_o = cnt_q_o - ONE;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q_o <= RST_VAL;
    else        cnt_q_o <= cnt_d_o;
  end

  // R5 R6
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && cnt_q_o == LIMIT) |=> (cnt_q_o == LIMIT));

  // R2 R3
  step_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && cnt_q_o != LIMIT) |=>
      (cnt_q_o == ((DIR == cwg_pkg::CNT_RISE) ? ($past(cnt_q_o) + ONE) : ($past(cnt_q_o) - ONE))));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(cnt_q_o));
endmodule

// File: rtl/cwg_ripple_adder.sv
module cwg_ripple_adder #(
  parameter int W = 6
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W:0]   sum_o
);
  logic [W:0]   carry;
  logic [W-1:0] bit_sum;

  assign carry[0] = 1'b0;

  generate
    for (genvar i = 0; i < W; i++) begin : g_fa
      assign bit_sum[i]  = a_i[i] ^ b_i[i] ^ carry[i];
      assign carry[i+1]  = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
    end
  endgenerate

  assign sum_o = {carry[W], bit_sum};

  // R10
  always_comb begin
    ripple_sum_chk: assert (sum_o == ({1'b0, a_i} + {1'b0, b_i}));
  end
endmodule

// File: rtl/cwg_therm_decoder.sv
module cwg_therm_decoder #(
  parameter int BW    = 7,
  parameter int OUT_W = 1 << BW
) (
  input  logic [BW-1:0]    val_i,
  output logic [OUT_W-1:0] therm_o
);
  generate
    for (genvar i = 0; i < OUT_W; i++) begin : g_pos
      assign therm_o[i] = (BW'(i) < val_i);
    end
  endgenerate

  // R8
  always_comb begin
    therm_pop_chk: assert ($countones(therm_o) == int'(val_i));
  end
endmodule

// File: rtl/ctrl_word_gen.sv
module ctrl_word_gen #(
  parameter int  CNT_W      = 6,
  localparam int WORD_W     = CNT_W + 1,
  localparam int THERM_FULL = 1 << WORD_W,
  localparam int THERM_USED = 2 * ((1 << CNT_W) - 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  up_en,
  input  logic                  dn_en,
  output logic [WORD_W-1:0]     ctrl_word,
  output logic [THERM_USED-1:0] therm_code
);
  localparam int MID = (1 << CNT_W) - 1;
  localparam logic [WORD_W-1:0]     WORD_RST  = WORD_W'(MID);
  localparam logic [THERM_USED-1:0] THERM_RST =
    {{(THERM_USED - MID){1'b0}}, {MID{1'b1}}};
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]      rise_d, rise_q, fall_d, fall_q;
  logic [WORD_W-1:0]     word_d;
  logic [THERM_FULL-1:0] therm_full;

  cwg_sat_counter #(.W(CNT_W), .DIR(cwg_pkg::CNT_RISE)) u_rise (
    .clk(clk), .rst_n(rst_n), .step_i(up_en), .cnt_d_o(rise_d), .cnt_q_o(rise_q)
  );

  cwg_sat_counter #(.W(CNT_W), .DIR(cwg_pkg::CNT_FALL)) u_fall (
    .clk(clk), .rst_n(rst_n), .step_i(dn_en), .cnt_d_o(fall_d), .cnt_q_o(fall_q)
  );

  cwg_ripple_adder #(.W(CNT_W)) u_add (
    .a_i(rise_d), .b_i(fall_d), .sum_o(word_d)
  );

  cwg_therm_decoder #(.BW(WORD_W), .OUT_W(THERM_FULL)) u_dec (
    .val_i(word_d), .therm_o(therm_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_word  <= WORD_RST;
      therm_code <= THERM_RST;
    end else begin
      ctrl_word  <= word_d;
      therm_code <= therm_full[THERM_USED-1:0];
    end
  end

  // R8: positions above the used range never set
  always_comb begin
    therm_top_zero_chk: assert (therm_full[THERM_FULL-1:THERM_USED] == '0);
  end

  // R10
  word_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word == ({1'b0, rise_q} + {1'b0, fall_q}));

  // R8
  therm_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(therm_code) == int'(ctrl_word));

  // R4
  both_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && dn_en && rise_q != CNT_MAX && fall_q != '0) |=> $stable(ctrl_word));

  // R7
  idle_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_en && !dn_en) |=> ($stable(ctrl_word) && $stable(therm_code)));
endmodule

// File: tb/test_ctrl_word_gen.sv
module test_ctrl_word_gen;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         up_en = 1'b0;
  logic         dn_en = 1'b0;
  logic [6:0]   ctrl_word;
  logic [125:0] therm_code;

  always #4 clk = ~clk;

  ctrl_word_gen i_ctrl_word_gen (
    .clk(clk), .rst_n(rst_n), .up_en(up_en), .dn_en(dn_en),
    .ctrl_word(ctrl_word), .therm_code(therm_code)
  );

  typedef struct {
    int    due;
    int    word;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  int   rise_m = 0;
  int   fall_m = 63;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [125:0] therm_of(int w);
    logic [125:0] t;
    for (int i = 0; i < 126; i++) t[i] = (i < w);
    return t;
  endfunction

  task automatic check_now(int w, string tag);
    logic [125:0] et;
    et = therm_of(w);
    checks++;
    if (int'(ctrl_word) != w) begin
      errors++;
      $display("FAIL %s word actual=%0d expected=%0d", tag, ctrl_word, w);
    end
    checks++;
    if (therm_code !== et) begin
      errors++;
      $display("FAIL %s therm actual=%h expected=%h", tag, therm_code, et);
    end
  endtask

  // monitor: pops scoreboard entries that have come due
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      check_now(e.word, e.tag);
    end
  end

  // driver: apply one cycle of enables at a negedge, predict the result
  task automatic drive(bit u, bit d, string tag);
    exp_t e;
    @(negedge clk);
    up_en = u;
    dn_en = d;
    if (u && rise_m < 63) rise_m++;
    if (d && fall_m > 0)  fall_m--;
    e.due  = cyc + 1;
    e.word = rise_m + fall_m;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  initial begin
    int lfsr;
    repeat (3) @(negedge clk);
    check_now(63, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    drive(0, 0, "R1 after release");
    drive(0, 0, "R7 idle");
    drive(0, 0, "R7 idle");
    for (int k = 0; k < 10; k++) drive(1, 0, "R2 R9 up step");
    for (int k = 0; k < 25; k++) drive(0, 1, "R3 R9 down step");
    for (int k = 0; k < 6; k++)  drive(1, 1, "R4 both");
    for (int k = 0; k < 70; k++) drive(1, 0, "R5 up to limit");
    drive(1, 1, "R4 both with rise saturated");
    drive(0, 0, "R7 idle at high word");
    for (int k = 0; k < 70; k++) drive(0, 1, "R6 down to limit");
    drive(1, 1, "R4 both with fall saturated");
    for (int k = 0; k < 70; k++) drive(1, 0, "R5 R10 top word");
    for (int k = 0; k < 70; k++) drive(0, 1, "R6 R10 bottom word");
    lfsr = 32'h1ACE;
    for (int k = 0; k < 400; k++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
      drive(lfsr[0], lfsr[3], "R8 R10 mixed");
    end
    drive(0, 0, "R7 final");
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    rise_m = 0;
    fall_m = 63;
    repeat (2) @(negedge clk);
    check_now(63, "R1 second reset");
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule